// File: doc/BRIEF.md
# Kick-Updated Fractional Clock Divider

This block turns every cycle of its parent clock into a clock-enable stream whose average rate is a programmable fraction of the parent. The fraction is `(32 - F) / 32`, where `F` is a 5-bit ratio field that software writes. The stream is then thinned by a fixed post-divider `POST_DIV`. A 5-bit accumulator produces the pulses. It adds the multiplier on every parent cycle and fires on carry, so the pulses are spread evenly across each 32-cycle frame.

Software writes the ratio field first. That write has no effect on the output yet: the field is only staged. Software then sets a kick flag in a second register. The block loads the staged ratio at the next 32-cycle frame boundary. It runs one full frame at the new ratio, then clears the kick flag in hardware. Software polls the flag to learn that the change is complete. While the flag is set, all writes to either register are dropped.

Top module: `ratio_kick_divider`

## Requirements
- R1: After reset the staged field reads 0, the kick flag reads 0, and the output runs at full rate (32 enables per 32·POST_DIV cycles).
- R2: A read at address 0x808 returns the staged field in bits FIELD_LSB+4..FIELD_LSB. A read at 0x804 returns the kick flag in bit 31. All other bits, and any other address, read as zero.
- R3: In steady state, every window of 32·POST_DIV consecutive parent cycles carries exactly 32−F enables, with POST_DIV = 2 by default.
- R4: The multiplier is 32−F and spans 1..32. F = 31 gives one enable per frame pair; F = 0 gives full rate.
- R5: Writing 0x804 with bit 31 = 1 sets the kick flag, and the flag reads back as 1 immediately. Writing it with bit 31 = 0 has no effect. Hardware clears the flag within 64 cycles of it being set.
- R6: While the kick flag is set, writes to 0x808 and 0x804 are ignored. The staged field and the ratio that finally takes effect are the values held before the kick.
- R7: A write to the ratio field alone leaves the output rate unchanged. The new ratio is loaded only at a 32-cycle frame boundary after a kick, and the kick flag clears only after one whole frame has run at the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| clk_en | output | 1 | Divided clock enable |

## Verification
The assertions assume two things: software never issues a write and a read in the same cycle, and FIELD_LSB leaves the 5-bit field inside the 32-bit word. Under those assumptions, the active multiplier never leaves 1..32 and changes only at a frame end. The kick flag falls only on the accumulator's completion strobe. The staged field holds still while a kick is pending. The stimulus meets these assumptions because each bus task issues exactly one access and then deasserts the strobe. It draws random field values only from the legal 5-bit range and deliberately writes during pending kicks to exercise the ignore path.

// File: rtl/ratio_div_pkg.sv
// Shared constants for the kick-updated fractional clock divider.
// Assumes a 32-bit register word and a 32-cycle accumulation frame.
package ratio_div_pkg;
    localparam logic [31:0] ADDR_KICK  = 32'h0000_0804;
    localparam logic [31:0] ADDR_RATIO = 32'h0000_0808;
    localparam int          KICK_BIT   = 31;
    localparam int          FIELD_W    = 5;
    localparam int          FRAME_LOG2 = FIELD_W;
    localparam int          MULT_W     = FIELD_W + 1;
endpackage

// File: rtl/ratio_div_regs.sv
// Register file: staged ratio field and self-clearing kick flag.
// Assumes done_i pulses only while the kick flag is set; reads are combinational.
module ratio_div_regs
    import ratio_div_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int FIELD_LSB = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 done_i,
    output logic [FIELD_W-1:0]   field_o,
    output logic                 kick_o
);
    logic [FIELD_W-1:0] field_q;
    logic               kick_q;
    logic               hit_ratio;
    logic               hit_kick;

    // Decode the two writable addresses.
    always_comb begin
        hit_ratio = bus_valid && bus_write && (bus_addr == ADDR_RATIO[ADDR_W-1:0]);
        hit_kick  = bus_valid && bus_write && (bus_addr == ADDR_KICK[ADDR_W-1:0]);
    end

    // Update staged field and kick flag; drop all writes while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            kick_q  <= 1'b0;
        end else if (kick_q) begin
            if (done_i) kick_q <= 1'b0;
        end else begin
            if (hit_ratio) field_q <= bus_wdata[FIELD_LSB +: FIELD_W];
            if (hit_kick && bus_wdata[KICK_BIT]) kick_q <= 1'b1;
        end
    end

    // Read mux; reserved bits and unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (bus_addr == ADDR_RATIO[ADDR_W-1:0])
                bus_rdata[FIELD_LSB +: FIELD_W] = field_q;
            else if (bus_addr == ADDR_KICK[ADDR_W-1:0])
                bus_rdata[KICK_BIT] = kick_q;
        end
    end

    assign field_o = field_q;
    assign kick_o  = kick_q;

    AST_FIELD_FROZEN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_q && $past(kick_q)) |-> $stable(field_q)); // R6
    AST_KICK_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick_q) |-> $past(done_i)); // R5
endmodule

// File: rtl/ratio_div_accum.sv
// Frame-aligned accumulator producing (32 - field) enables per 32 cycles.
// Assumes kick_i stays high until done_o has been seen.
module ratio_div_accum
    import ratio_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kick_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               base_en_o,
    output logic               done_o
);
    localparam logic [MULT_W-1:0] FULL_MULT = MULT_W'(1 << FRAME_LOG2);

    logic [FRAME_LOG2-1:0] frame_cnt;
    logic [FIELD_W-1:0]    acc_q;
    logic [MULT_W-1:0]     mult_q;
    logic [MULT_W-1:0]     sum;
    logic                  loaded_q;
    logic                  frame_last;

    // Accumulate the multiplier; carry marks an enable.
    always_comb begin
        sum        = {1'b0, acc_q} + mult_q;
        frame_last = (frame_cnt == '1);
        base_en_o  = sum[MULT_W-1];
        done_o     = loaded_q && frame_last;
    end

    // Frame counter, ratio load at frame end, and completion tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            acc_q     <= '0;
            mult_q    <= FULL_MULT;
            loaded_q  <= 1'b0;
        end else begin
            frame_cnt <= frame_cnt + 1'b1;
            if (kick_i && !loaded_q && frame_last) begin
                mult_q   <= FULL_MULT - {1'b0, field_i};
                acc_q    <= '0;
                loaded_q <= 1'b1;
            end else begin
                acc_q <= sum[FIELD_W-1:0];
                if (done_o) loaded_q <= 1'b0;
            end
        end
    end

    AST_MULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_q >= MULT_W'(1)) && (mult_q <= FULL_MULT)); // R4
    AST_LOAD_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_q != $past(mult_q)) |-> ($past(frame_cnt) == '1)); // R7
endmodule

// File: rtl/ratio_div_post.sv
// Fixed post-divider: passes every POST_DIV-th base enable.
// Assumes POST_DIV >= 1; POST_DIV == 1 is a straight pass-through.
module ratio_div_post #(
    parameter int POST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic en_o
);
    localparam int CNT_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;

    generate
        if (POST_DIV == 1) begin : g_pass
            assign en_o = en_i;
        end else begin : g_div
            logic [CNT_W-1:0] cnt_q;
            logic             last;

            // Flag the last base enable of each group.
            always_comb last = (cnt_q == CNT_W'(POST_DIV - 1));

            // Count base enables modulo POST_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)    cnt_q <= '0;
                else if (en_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
            end

            assign en_o = en_i && last;
        end
    endgenerate

    AST_OUT_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> en_i); // R3
endmodule

// File: rtl/ratio_kick_divider.sv
// Top: register file, frame accumulator and post-divider wired together.
// Assumes FIELD_LSB + 5 <= 32 and one bus access per cycle.
module ratio_kick_divider
    import ratio_div_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int FIELD_LSB = 8,
    parameter int POST_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              clk_en
);
    logic [FIELD_W-1:0] field;
    logic               kick;
    logic               done;
    logic               base_en;

    ratio_div_regs #(.ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_i(done), .field_o(field), .kick_o(kick)
    );

    ratio_div_accum u_accum (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .field_i(field),
        .base_en_o(base_en), .done_o(done)
    );

    ratio_div_post #(.POST_DIV(POST_DIV)) u_post (
        .clk(clk), .rst_n(rst_n), .en_i(base_en), .en_o(clk_en)
    );
endmodule

// File: tb/sim_ratio_kick_divider.sv
module sim_ratio_kick_divider;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int FIELD_LSB  = 8;
    localparam int POST_DIV   = 2;
    localparam int WINDOW     = 32 * POST_DIV;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              clk_en;
    int                errors = 0;
    int                checks = 0;

    ratio_kick_divider #(.ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB), .POST_DIV(POST_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_count(input int f);
        return 32 - f;
    endfunction

    function automatic logic [31:0] exp_ratio_word(input int f);
        return 32'(f) << FIELD_LSB;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[ADDR_W-1:0];
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < WINDOW; i++) begin
            @(negedge clk);
            if (clk_en) n++;
        end
    endtask

    // Poll the kick flag; returns the number of polls taken.
    task automatic wait_kick(output int polls);
        logic [31:0] r;
        polls = 0;
        for (int i = 0; i < 80; i++) begin
            bus_rd(32'h804, r);
            if (r[31] == 1'b0) break;
            polls++;
            @(negedge clk);
        end
    endtask

    task automatic update(input int f, input string tag);
        int polls, n;
        logic [31:0] r;
        bus_wr(32'h808, exp_ratio_word(f));
        bus_wr(32'h804, 32'h8000_0000);
        wait_kick(polls);
        check({tag, " R5 kick clears in time"}, 32'(polls <= 66), 32'd1);
        bus_rd(32'h808, r);
        check({tag, " R2 field readback"}, r, exp_ratio_word(f));
        measure(n);
        check({tag, " R3 rate"}, 32'(n), 32'(exp_count(f)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int n, polls, seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(32'h808, r);  check("R1 field after reset", r, 32'h0);
        bus_rd(32'h804, r);  check("R1 kick after reset", r, 32'h0);
        measure(n);          check("R1 full rate after reset", 32'(n), 32'd32);

        // R2 reserved bits and unmapped address
        bus_wr(32'h808, 32'hFFFF_FFFF);
        bus_rd(32'h808, r);  check("R2 reserved bits zero", r, exp_ratio_word(31));
        bus_rd(32'h800, r);  check("R2 unmapped reads zero", r, 32'h0);

        // R7 field write alone does not change rate
        measure(n);          check("R7 no effect without kick", 32'(n), 32'd32);

        // R5 kick write with bit31 = 0 is ignored
        bus_wr(32'h804, 32'h7FFF_FFFF);
        bus_rd(32'h804, r);  check("R5 kick needs bit31", r, 32'h0);

        // R5 kick reads back set; R6 writes during busy ignored
        bus_wr(32'h804, 32'h8000_0000);
        bus_rd(32'h804, r);  check("R5 kick set", r, 32'h8000_0000);
        bus_wr(32'h808, exp_ratio_word(3));
        bus_wr(32'h804, 32'h8000_0000);
        wait_kick(polls);
        check("R5 kick clears within 64", 32'(polls <= 66), 32'd1);
        check("R7 kick holds a full frame", 32'(polls >= 30), 32'd1);
        bus_rd(32'h808, r);  check("R6 busy write ignored", r, exp_ratio_word(31));
        measure(n);          check("R4 minimum multiplier", 32'(n), 32'(exp_count(31)));

        // Directed corners
        update(0,  "corner full");
        update(16, "corner half");
        update(1,  "corner max-1");

        // Random ratios
        for (int k = 0; k < 8; k++) begin
            update(int'($urandom_range(31, 0)), "random");
        end

        finish_run();
    end
endmodule